// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Access Controller

This block sits on the synchronous side of a chip and drives an external pseudo-SRAM. The memory has a 16-bit data bus, two byte-lane strobes and a 22-bit word address. After reset, the controller counts out a power-up settling interval while it holds chip enable inactive. It then serves single read and write requests from a valid/ready request port. Each request carries an address, write data and a two-bit byte-enable mask. Every phase of the strobe sequence lasts a whole number of clock cycles, and each of those cycle counts is a parameter.

The request port follows the usual stream rules. A request stays on the inputs until it is accepted. It is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low during the power-up wait and whenever an access or its recovery is in progress, so the requester is held off for the whole duration of each access. The response side has no back-pressure. `rsp_valid` is a one-cycle pulse that carries read data, and writes produce no response.

The data bus is presented as separate output, output-enable and input vectors. The tri-state pad is built outside this block.

Top module: `psram_async_ctrl`

## Requirements
- R1: While `rst_n` is low, `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` are high, and `mem_dq_oe`, `req_ready` and `rsp_valid` are low.
- R2: After reset is released, `req_ready` first reads high after exactly INIT_CYCLES rising edges. `mem_ce_n` stays high throughout that interval.
- R3: `req_ready` is high only after initialization and only while no access or recovery is in progress. It is low in the cycle after a request with a non-zero mask is accepted. A request held during initialization is accepted afterwards and carried out.
- R4: A read drives `mem_ce_n` and `mem_oe_n` low and keeps `mem_we_n` high for exactly ACC_CYCLES cycles. During those cycles, `mem_addr` equals the request address, and each byte strobe is low only if its mask bit is set. Mask bit 0 selects `mem_lb_n` (data bits 7:0) and mask bit 1 selects `mem_ub_n` (data bits 15:8).
- R5: Read data is sampled at the clock edge that ends the last access cycle. It appears on `rsp_rdata` with a one-cycle `rsp_valid` pulse in the following cycle.
- R6: A write drives `mem_ce_n` and `mem_we_n` low with `mem_oe_n` high. The byte strobes follow the mask as in R4.
- R7: The write strobe stays low for min(WR_CYCLES, CEM_CYCLES-1) consecutive cycles, so it never reaches CEM_CYCLES.
- R8: `mem_dq_oe` is high only while `mem_we_n` is low and for the single hold cycle after it rises. `mem_addr` and `mem_dq_o` hold steady from the start of the write until the end of that hold cycle.
- R9: At the rising edge of the write strobe, the memory word receives only the lanes whose byte strobe was low. The other lane keeps its contents.
- R10: Between accesses, `mem_ce_n` is high for exactly REC_CYCLES+1 cycles after a read and REC_CYCLES+2 cycles after a write, when the next request is already waiting.
- R11: A request with mask 2'b00 is accepted without any strobe going low. A read of this kind returns `rsp_valid` with `rsp_rdata` = 0 in the next cycle. A write of this kind leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Data pad output enable |
| mem_dq_i | input | 16 | Data from memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte strobe, active low |
| mem_ub_n | output | 1 | High byte strobe, active low |

## Verification
A phase counter that drifts shows up in the cycle where a strobe pulse should end. The width of the OE or WE pulse is wrong, or read data comes back with the placeholder value that the bench memory model returns before the access time has passed. A phase register stuck in the wrong state shows up within one cycle: strobes overlap, the data bus drives during a read, `req_ready` is high while chip enable is low, or chip enable drops during the power-up wait. A latched request word that is corrupted shows up at the next access as a wrong address, wrong lanes or a wrong merged memory word.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;
  localparam int DQ_W  = 16;
  localparam int LANES = DQ_W / 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_WRITE,
    PH_HOLD,
    PH_RECOVER
  } phase_e;
endpackage

// File: rtl/psram_init_timer.sv
module psram_init_timer #(
  parameter int INIT_CYCLES = 37500
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CW = $clog2(INIT_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  // Saturating count of edges since reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_q != CW'(INIT_CYCLES))
      cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == CW'(INIT_CYCLES));
endmodule

// File: rtl/psram_phase_fsm.sv
module psram_phase_fsm
  import psram_ctrl_pkg::*;
#(
  parameter int ACC_CYCLES = 18,
  parameter int WE_CYCLES  = 14,
  parameter int REC_CYCLES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go,
  input  logic   go_write,
  output phase_e phase,
  output logic   capture
);
  localparam int MAX_AW = (ACC_CYCLES > WE_CYCLES) ? ACC_CYCLES : WE_CYCLES;
  localparam int MAXC   = (MAX_AW > REC_CYCLES) ? MAX_AW : REC_CYCLES;
  localparam int CW     = $clog2(MAXC + 1);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (go) ph_q <= go_write ? PH_WRITE : PH_READ;
        end
        PH_READ: begin
          if (cnt_q == CW'(ACC_CYCLES - 1)) begin
            ph_q  <= PH_RECOVER;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_WRITE: begin
          if (cnt_q == CW'(WE_CYCLES - 1)) begin
            ph_q  <= PH_HOLD;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_HOLD: begin
          ph_q  <= PH_RECOVER;
          cnt_q <= '0;
        end
        PH_RECOVER: begin
          if (cnt_q == CW'(REC_CYCLES - 1)) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign phase   = ph_q;
  assign capture = (ph_q == PH_READ) && (cnt_q == CW'(ACC_CYCLES - 1));
endmodule

// File: rtl/psram_strobe_gen.sv
module psram_strobe_gen
  import psram_ctrl_pkg::*;
(
  input  phase_e           phase,
  input  logic [LANES-1:0] lane_en,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic [LANES-1:0] lane_n,
  output logic             dq_oe
);
  logic access;

  // Decoded straight from the phase register, so each strobe changes once per edge.
  assign access = (phase == PH_READ) || (phase == PH_WRITE);
  assign ce_n   = ~access;
  assign oe_n   = ~(phase == PH_READ);
  assign we_n   = ~(phase == PH_WRITE);
  assign dq_oe  = (phase == PH_WRITE) || (phase == PH_HOLD);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_n[g] = ~(access && lane_en[g]);
  end
endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int INIT_CYCLES = 37500,
  parameter int ACC_CYCLES  = 18,
  parameter int WR_CYCLES   = 14,
  parameter int CEM_CYCLES  = 1000,
  parameter int REC_CYCLES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [DQ_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DQ_W-1:0]   mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DQ_W-1:0]   mem_dq_i,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n
);
  // Write pulse is clipped one cycle short of the chip-enable-low ceiling.
  localparam int WE_EFF = (WR_CYCLES < CEM_CYCLES) ? WR_CYCLES : CEM_CYCLES - 1;

  logic              init_done;
  logic              capture;
  logic              accept;
  logic              has_lane;
  phase_e            phase;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   wdata_q;
  logic [LANES-1:0]  be_q;
  logic [LANES-1:0]  lane_n;

  psram_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk  (clk),
    .rst_n(rst_n),
    .done (init_done)
  );

  assign req_ready = init_done && (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign has_lane  = |req_be;

  psram_phase_fsm #(
    .ACC_CYCLES(ACC_CYCLES),
    .WE_CYCLES (WE_EFF),
    .REC_CYCLES(REC_CYCLES)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (accept && has_lane),
    .go_write(req_write),
    .phase   (phase),
    .capture (capture)
  );

  // Request word is latched only at acceptance, keeping address and data still.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture || (accept && !has_lane && !req_write);
      if (capture)
        rsp_rdata <= mem_dq_i;
      else if (accept && !has_lane && !req_write)
        rsp_rdata <= '0;
    end
  end

  psram_strobe_gen u_strb (
    .phase  (phase),
    .lane_en(be_q),
    .ce_n   (mem_ce_n),
    .oe_n   (mem_oe_n),
    .we_n   (mem_we_n),
    .lane_n (lane_n),
    .dq_oe  (mem_dq_oe)
  );

  assign mem_lb_n = lane_n[0];
  assign mem_ub_n = lane_n[1];
  assign mem_addr = addr_q;
  assign mem_dq_o = wdata_q;
endmodule

// File: rtl/psram_ctrl_props.sv
module psram_ctrl_props #(
  parameter int ADDR_W     = 22,
  parameter int CEM_CYCLES = 1000,
  parameter int REC_CYCLES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_done,
  input logic              req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_dq_o,
  input logic              mem_dq_oe,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n
);
  localparam int WCW = $clog2(CEM_CYCLES + 1);
  localparam int HCW = $clog2(REC_CYCLES + 3);

  logic [WCW-1:0] we_run;
  logic [HCW-1:0] hi_run;

  // Consecutive write-strobe-low cycles, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_run <= '0;
    else if (mem_we_n) we_run <= '0;
    else if (we_run != WCW'(CEM_CYCLES)) we_run <= we_run + 1'b1;
  end

  // Consecutive chip-enable-high cycles, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= HCW'(REC_CYCLES + 2);
    else if (!mem_ce_n) hi_run <= '0;
    else if (hi_run != HCW'(REC_CYCLES + 2)) hi_run <= hi_run + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  assert_init_ce_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (mem_ce_n && !req_ready));

  assert_ready_only_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_dq_oe));

  assert_read_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));

  assert_write_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  assert_lanes_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_lb_n && mem_ub_n && mem_oe_n && mem_we_n));

  assert_we_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (we_run < WCW'(CEM_CYCLES - 1)));

  assert_dq_drive_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n || !$past(mem_we_n)));

  assert_dq_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> ($stable(mem_dq_o) && $stable(mem_addr)));

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_recovery_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (hi_run > HCW'(REC_CYCLES)));

  assert_some_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !(mem_lb_n && mem_ub_n));
endmodule

bind psram_async_ctrl psram_ctrl_props #(
  .ADDR_W    (ADDR_W),
  .CEM_CYCLES(CEM_CYCLES),
  .REC_CYCLES(REC_CYCLES)
) u_props (
  .clk      (clk),
  .rst_n    (rst_n),
  .init_done(init_done),
  .req_ready(req_ready),
  .mem_addr (mem_addr),
  .mem_dq_o (mem_dq_o),
  .mem_dq_oe(mem_dq_oe),
  .mem_ce_n (mem_ce_n),
  .mem_oe_n (mem_oe_n),
  .mem_we_n (mem_we_n),
  .mem_lb_n (mem_lb_n),
  .mem_ub_n (mem_ub_n)
);

// File: tb/psram_async_ctrl_bench.sv
`timescale 1ns/1ps
module psram_async_ctrl_bench;
  localparam int AW     = 22;
  localparam int INIT   = 20;
  localparam int ACC    = 3;
  localparam int WRC    = 8;
  localparam int CEM    = 5;
  localparam int REC    = 2;
  localparam int WE_EXP = (WRC < CEM) ? WRC : CEM - 1;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [15:0]   data;
    logic [1:0]    be;
    logic [15:0]   exp;
  } vec_t;

  // exp: memory word after a write, or returned data for a read.
  localparam vec_t VECS [9] = '{
    '{1'b1, 22'h000001, 16'h1234, 2'b11, 16'h1234},
    '{1'b0, 22'h000001, 16'h0000, 2'b11, 16'h1234},
    '{1'b1, 22'h000002, 16'hABCD, 2'b01, 16'h5ACD},
    '{1'b0, 22'h000002, 16'h0000, 2'b11, 16'h5ACD},
    '{1'b1, 22'h000003, 16'h7788, 2'b10, 16'h7703},
    '{1'b0, 22'h000003, 16'h0000, 2'b10, 16'h7703},
    '{1'b0, 22'h000005, 16'h0000, 2'b01, 16'h5A05},
    '{1'b1, 22'h3FFFFF, 16'hFFEE, 2'b11, 16'hFFEE},
    '{1'b0, 22'h3FFFFF, 16'h0000, 2'b11, 16'hFFEE}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic          rsp_valid;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_dq_o;
  logic          mem_dq_oe;
  logic [15:0]   mem_dq_i;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  psram_async_ctrl #(
    .ADDR_W(AW), .INIT_CYCLES(INIT), .ACC_CYCLES(ACC),
    .WR_CYCLES(WRC), .CEM_CYCLES(CEM), .REC_CYCLES(REC)
  ) u_psram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n)
  );

  // Memory model and port monitor, updated away from the active edge.
  logic [15:0] mdl [16];
  int rd_run = 0, we_run = 0, oe_run = 0, hi_run = 0;
  int last_we = 0, last_oe = 0, mon_gap = 0, ce_falls = 0, bad_drive = 0;
  logic [AW-1:0] mon_addr = '0;
  logic mon_lb = 1'b1, mon_ub = 1'b1;
  logic p_ce = 1'b1, p_we = 1'b1, p_lb = 1'b1, p_ub = 1'b1;

  initial for (int i = 0; i < 16; i++) mdl[i] = 16'h5A00 | 16'(i);

  always_comb begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_i = (rd_run >= ACC) ? mdl[mem_addr[3:0]] : 16'hBAD0;
    else
      mem_dq_i = 16'h0000;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && p_ce) begin
        mon_gap  = hi_run;
        mon_addr = mem_addr;
        mon_lb   = mem_lb_n;
        mon_ub   = mem_ub_n;
        ce_falls++;
      end
      if (mem_ce_n) hi_run++; else hi_run = 0;
      if (!mem_we_n) we_run++;
      else if (we_run != 0) begin last_we = we_run; we_run = 0; end
      if (!mem_oe_n) oe_run++;
      else if (oe_run != 0) begin last_oe = oe_run; oe_run = 0; end
      if (!p_we && mem_we_n) begin
        if (!mem_dq_oe) bad_drive++;
        if (!p_lb) mdl[mem_addr[3:0]][7:0]  = mem_dq_o[7:0];
        if (!p_ub) mdl[mem_addr[3:0]][15:8] = mem_dq_o[15:8];
      end
      if (mem_dq_oe && mem_we_n && p_we) bad_drive++;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_run++; else rd_run = 0;
      p_ce = mem_ce_n; p_we = mem_we_n; p_lb = mem_lb_n; p_ub = mem_ub_n;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic wr, input logic [AW-1:0] a, input logic [15:0] d,
                      input logic [1:0] be);
    req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    bit ce_seen_low;
    logic [31:0] prev_wr;
    @(negedge clk); @(negedge clk);
    // R1: reset state at the ports
    chk({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready, rsp_valid}
        == 8'b11111000, "R1", {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n,
        mem_dq_oe, req_ready, rsp_valid}, 8'b11111000);
    // Request held from before reset release (R3), init interval (R2)
    req_write = 1'b1; req_addr = 22'h4; req_wdata = 16'h4444; req_be = 2'b11;
    req_valid = 1'b1;
    rst_n = 1'b1;
    n = 0; ce_seen_low = 0;
    while (!req_ready) begin
      @(negedge clk);
      n++;
      if (!mem_ce_n) ce_seen_low = 1;
    end
    chk(n == INIT, "R2 ready delay", n, INIT);
    chk(!ce_seen_low, "R2 ce high in init", ce_seen_low, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R3 ready low when busy", req_ready, 0);
    wait_ready();
    chk(mdl[4] == 16'h4444, "R3 held request done", mdl[4], 16'h4444);

    prev_wr = 1;
    for (int i = 0; i < 9; i++) begin
      send(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].be);
      chk(!req_ready, "R3 busy", req_ready, 0);
      if (VECS[i].wr) begin
        wait_ready();
        chk(last_we == WE_EXP, "R7 we width", last_we, WE_EXP);
        chk(mdl[VECS[i].addr[3:0]] == VECS[i].exp, "R9 merged word",
            mdl[VECS[i].addr[3:0]], VECS[i].exp);
        chk(mon_addr == VECS[i].addr, "R6 address", mon_addr, VECS[i].addr);
        chk({mon_ub, mon_lb} == ~VECS[i].be, "R6 lanes", {mon_ub, mon_lb}, ~VECS[i].be);
      end else begin
        while (!rsp_valid) @(negedge clk);
        chk(rsp_rdata == VECS[i].exp, "R5 read data", rsp_rdata, VECS[i].exp);
        @(negedge clk);
        chk(!rsp_valid, "R5 single pulse", rsp_valid, 0);
        wait_ready();
        chk(last_oe == ACC, "R4 oe width", last_oe, ACC);
        chk(mon_addr == VECS[i].addr, "R4 address", mon_addr, VECS[i].addr);
        chk({mon_ub, mon_lb} == ~VECS[i].be, "R4 lanes", {mon_ub, mon_lb}, ~VECS[i].be);
      end
      if (i > 0)
        chk(mon_gap == (prev_wr != 0 ? REC + 2 : REC + 1), "R10 ce gap", mon_gap,
            (prev_wr != 0 ? REC + 2 : REC + 1));
      prev_wr = VECS[i].wr;
    end
    chk(bad_drive == 0, "R8 drive window", bad_drive, 0);

    // R11: empty-mask requests
    n = ce_falls;
    send(1'b0, 22'h1, 16'h0, 2'b00);
    chk(rsp_valid && rsp_rdata == 16'h0, "R11 empty read rsp", {rsp_valid, rsp_rdata},
        {1'b1, 16'h0});
    send(1'b1, 22'h1, 16'h0000, 2'b00);
    repeat (6) @(negedge clk);
    chk(ce_falls == n, "R11 no strobes", ce_falls, n);
    chk(mdl[1] == 16'h1234, "R11 memory unchanged", mdl[1], 16'h1234);
    send(1'b0, 22'h1, 16'h0, 2'b11);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_rdata == 16'h1234, "R11 readback", rsp_rdata, 16'h1234);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule